// File: doc/BRIEF.md
# Chip-Select Gated Duplicating Command Register

This block is a registered command/address buffer. On each rising clock edge it captures a bank of gated data bits and three control bits: chip select, clock enable and on-die termination. Each captured bit drives two output copies, A and B, which always hold the same value. The two copies let one register feed two separate fan-out trees.

Two active-low chip-select inputs gate the data bank. When both are high at an edge, the data outputs keep their last value, so idle bus cycles cause no output toggling. The clock-enable and termination bits are not gated, and the registered chip select follows the primary chip-select input on every edge. Holding the secondary select low removes the gating, and the data bank then updates on every clock.

An active-low reset clears every register at once, without waiting for a clock. Its release is synchronised through a short register chain before capture resumes. As a result, the outputs stay low and free of glitches while the inputs settle.

Top module: `csgr_dup_register`

## Requirements
- R1: Output copies A and B of every data bit and of every control bit are equal at all times.
- R2: At an active edge where at least one of `cs_pri_n`, `cs_sec_n` is low, `q_a`/`q_b` take the value `din` had at that edge.
- R3: At an active edge where both `cs_pri_n` and `cs_sec_n` are high, `q_a`/`q_b` keep their previous value.
- R4: `cke_a`/`cke_b` and `odt_a`/`odt_b` take `cke_in` and `odt_in` at every active edge, whatever the chip-select levels.
- R5: `cs_a`/`cs_b` take the level of `cs_pri_n` at every active edge.
- R6: While `rst_n` is low, every output is 0. A falling `rst_n` clears the outputs with no clock edge, and this overrides the gating.
- R7: After `rst_n` rises, the first two rising clock edges capture nothing and the outputs stay 0. The third edge is the first active edge.
- R8: With `cs_sec_n` held low, the data outputs update at every active edge, even while `cs_pri_n` is high.
- R9: If the inputs are held low across the release of reset, every output stays 0 on every cycle after the release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| cs_pri_n | input | 1 | Primary chip select, active low; also re-driven |
| cs_sec_n | input | 1 | Secondary chip select, active low; gates data only |
| din | input | DATA_W | Gated data inputs |
| cke_in | input | 1 | Clock-enable input, ungated |
| odt_in | input | 1 | Termination-control input, ungated |
| q_a | output | DATA_W | Data outputs, copy A |
| q_b | output | DATA_W | Data outputs, copy B |
| cs_a | output | 1 | Registered chip select, copy A |
| cs_b | output | 1 | Registered chip select, copy B |
| cke_a | output | 1 | Registered clock enable, copy A |
| cke_b | output | 1 | Registered clock enable, copy B |
| odt_a | output | 1 | Registered termination control, copy A |
| odt_b | output | 1 | Registered termination control, copy B |

## Verification
The data bank is driven with random words under all four chip-select combinations. A hold after a both-high edge is therefore told apart from a capture of a word that happens to match, and the ungated control bits are seen moving while the data is frozen. A run with the secondary select held low and the primary select high separates the two selects' roles. Reset is released once with the inputs low and once with non-zero inputs, which pins down the exact edge of the first capture. Reset is also dropped in the middle of a gated cycle, to show that the clear needs no clock and overrides the hold.

// File: rtl/csgr_pkg.sv
package csgr_pkg;
  // Ungated control bits captured every active edge
  typedef struct packed {
    logic cs;
    logic cke;
    logic odt;
  } csgr_ctrl_t;

  localparam int unsigned CSGR_NCOPY = 2;
endpackage

// File: rtl/csgr_reset_sync.sv
module csgr_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_live
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] chain;

  // Clears at once on a falling rst_n; ones shift in after release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rst_live = ~chain[LAST];
endmodule

// File: rtl/csgr_gate.sv
module csgr_gate (
  input  logic cs_pri_n,
  input  logic cs_sec_n,
  output logic data_upd
);
  // Data bank updates unless both selects are idle (high)
  always_comb data_upd = ~(cs_pri_n & cs_sec_n);
endmodule

// File: rtl/csgr_copy_bank.sv
module csgr_copy_bank
  import csgr_pkg::*;
#(
  parameter int unsigned DATA_W = 11
) (
  input  logic              clk,
  input  logic              rst_live,
  input  logic              data_upd,
  input  logic [DATA_W-1:0] din,
  input  csgr_ctrl_t        ctrl_in,
  output logic [DATA_W-1:0] q,
  output csgr_ctrl_t        ctrl_q
);
  always_ff @(posedge clk or posedge rst_live) begin
    if (rst_live)      q <= '0;
    else if (data_upd) q <= din;
  end

  always_ff @(posedge clk or posedge rst_live) begin
    if (rst_live) ctrl_q <= '0;
    else          ctrl_q <= ctrl_in;
  end
endmodule

// File: rtl/csgr_dup_register.sv
module csgr_dup_register
  import csgr_pkg::*;
#(
  parameter int unsigned DATA_W      = 11,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_pri_n,
  input  logic              cs_sec_n,
  input  logic [DATA_W-1:0] din,
  input  logic              cke_in,
  input  logic              odt_in,
  output logic [DATA_W-1:0] q_a,
  output logic [DATA_W-1:0] q_b,
  output logic              cs_a,
  output logic              cs_b,
  output logic              cke_a,
  output logic              cke_b,
  output logic              odt_a,
  output logic              odt_b
);
  logic       rst_live;
  logic       data_upd;
  csgr_ctrl_t ctrl_in;
  logic       [DATA_W-1:0] q_copy    [CSGR_NCOPY];
  csgr_ctrl_t              ctrl_copy [CSGR_NCOPY];

  csgr_reset_sync #(.STAGES(SYNC_STAGES)) u_rsync (
    .clk      (clk),
    .rst_n    (rst_n),
    .rst_live (rst_live)
  );

  csgr_gate u_gate (
    .cs_pri_n (cs_pri_n),
    .cs_sec_n (cs_sec_n),
    .data_upd (data_upd)
  );

  always_comb begin
    ctrl_in.cs  = cs_pri_n;
    ctrl_in.cke = cke_in;
    ctrl_in.odt = odt_in;
  end

  for (genvar c = 0; c < CSGR_NCOPY; c++) begin : g_copy
    csgr_copy_bank #(.DATA_W(DATA_W)) u_bank (
      .clk      (clk),
      .rst_live (rst_live),
      .data_upd (data_upd),
      .din      (din),
      .ctrl_in  (ctrl_in),
      .q        (q_copy[c]),
      .ctrl_q   (ctrl_copy[c])
    );
  end

  assign q_a   = q_copy[0];
  assign q_b   = q_copy[1];
  assign cs_a  = ctrl_copy[0].cs;
  assign cs_b  = ctrl_copy[1].cs;
  assign cke_a = ctrl_copy[0].cke;
  assign cke_b = ctrl_copy[1].cke;
  assign odt_a = ctrl_copy[0].odt;
  assign odt_b = ctrl_copy[1].odt;
endmodule

// File: rtl/csgr_dup_register_chk.sv
module csgr_dup_register_chk #(
  parameter int unsigned DATA_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rst_live,
  input logic              cs_pri_n,
  input logic              cs_sec_n,
  input logic [DATA_W-1:0] din,
  input logic              cke_in,
  input logic              odt_in,
  input logic [DATA_W-1:0] q_a,
  input logic [DATA_W-1:0] q_b,
  input logic              cs_a,
  input logic              cs_b,
  input logic              cke_a,
  input logic              cke_b,
  input logic              odt_a,
  input logic              odt_b
);
  a_r1_copies_equal: assert property (@(posedge clk)
    (q_a == q_b) && (cs_a == cs_b) && (cke_a == cke_b) && (odt_a == odt_b));

  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_live && !(cs_pri_n && cs_sec_n)) |=> (q_a == $past(din)));

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_live && cs_pri_n && cs_sec_n) |=> $stable(q_a));

  a_r4_ctrl_ungated: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_live |=> (cke_a == $past(cke_in)) && (odt_a == $past(odt_in)));

  a_r5_cs_follow: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_live |=> (cs_a == $past(cs_pri_n)));

  a_r6_reset_clear: assert property (@(posedge clk)
    !rst_n |-> (q_a == '0) && !cs_a && !cke_a && !odt_a);

  a_r7_quiet_release: assert property (@(posedge clk)
    rst_live |-> (q_b == '0) && !cs_b && !cke_b && !odt_b);
endmodule

bind csgr_dup_register csgr_dup_register_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rst_live (rst_live),
  .cs_pri_n (cs_pri_n),
  .cs_sec_n (cs_sec_n),
  .din      (din),
  .cke_in   (cke_in),
  .odt_in   (odt_in),
  .q_a      (q_a),
  .q_b      (q_b),
  .cs_a     (cs_a),
  .cs_b     (cs_b),
  .cke_a    (cke_a),
  .cke_b    (cke_b),
  .odt_a    (odt_a),
  .odt_b    (odt_b)
);

// File: tb/csgr_dup_register_bench.sv
module csgr_dup_register_bench;
  localparam int W = 11;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cs_pri_n = 1'b1, cs_sec_n = 1'b1;
  logic [W-1:0] din = '0;
  logic         cke_in = 1'b0, odt_in = 1'b0;
  logic [W-1:0] q_a, q_b;
  logic         cs_a, cs_b, cke_a, cke_b, odt_a, odt_b;

  int checks = 0, fails = 0;
  string phase = "R6";

  always #2 clk = ~clk;

  csgr_dup_register u_csgr_dup_register (
    .clk(clk), .rst_n(rst_n), .cs_pri_n(cs_pri_n), .cs_sec_n(cs_sec_n),
    .din(din), .cke_in(cke_in), .odt_in(odt_in),
    .q_a(q_a), .q_b(q_b), .cs_a(cs_a), .cs_b(cs_b),
    .cke_a(cke_a), .cke_b(cke_b), .odt_a(odt_a), .odt_b(odt_b)
  );

  // Behavioural reference: edges since release, then the gating rule
  int           m_edges = 0;
  logic [W-1:0] m_q = '0;
  logic         m_cs = 0, m_cke = 0, m_odt = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_edges = 0; m_q = '0; m_cs = 0; m_cke = 0; m_odt = 0;
    end else begin
      if (m_edges >= 2) begin
        if (!(cs_pri_n && cs_sec_n)) m_q = din;
        m_cs = cs_pri_n; m_cke = cke_in; m_odt = odt_in;
      end
      if (m_edges < 2) m_edges++;
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(string tag);
    chk(tag, "q_a", int'(q_a), int'(m_q));
    chk(tag, "cs_a", int'(cs_a), int'(m_cs));
    chk(tag, "cke_a", int'(cke_a), int'(m_cke));
    chk(tag, "odt_a", int'(odt_a), int'(m_odt));
    chk("R1", "copy B data", int'(q_b), int'(q_a));
    chk("R1", "copy B ctrl", int'({cs_b, cke_b, odt_b}), int'({cs_a, cke_a, odt_a}));
  endtask

  always @(negedge clk) compare_all(phase);

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rand_inputs();
    din = W'($urandom); cke_in = 1'($urandom); odt_in = 1'($urandom);
  endtask

  initial begin : watchdog
    #400000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R6: reset state
    cycles(3);
    // R9: release with inputs held low
    phase = "R9";
    cs_pri_n = 0; cs_sec_n = 0;
    rst_n = 1;
    cycles(6);
    // R7: re-enter reset, release with non-zero inputs; first capture on 3rd edge
    phase = "R6"; rst_n = 0; cycles(2);
    phase = "R7";
    din = 11'h5A5; cke_in = 1; odt_in = 1; cs_pri_n = 1; cs_sec_n = 0;
    rst_n = 1;
    @(negedge clk); chk("R7", "edge1 q_a", int'(q_a), 0);
    @(negedge clk); chk("R7", "edge2 q_a", int'(q_a), 0);
    @(negedge clk); chk("R7", "edge3 q_a", int'(q_a), 'h5A5);
    chk("R7", "edge3 cke_a", int'(cke_a), 1);
    // R2/R3/R4/R5: all four select combinations with random words
    for (int i = 0; i < 200; i++) begin
      int sel = i % 4;
      cs_pri_n = sel[0]; cs_sec_n = sel[1];
      phase = (sel == 3) ? "R3" : "R2";
      rand_inputs();
      @(negedge clk);
      if (sel == 3) chk("R4", "ctrl during hold", int'({cke_a, odt_a}), int'({cke_in, odt_in}));
      chk("R5", "cs follows", int'(cs_a), int'(cs_pri_n));
    end
    // R3: long hold with both selects high, data moving
    phase = "R3"; cs_pri_n = 1; cs_sec_n = 1;
    for (int i = 0; i < 40; i++) begin rand_inputs(); @(negedge clk); end
    // R8: secondary select tied low, primary high
    phase = "R8"; cs_sec_n = 0; cs_pri_n = 1;
    for (int i = 0; i < 40; i++) begin
      rand_inputs(); @(negedge clk);
      chk("R8", "q_a tracks din", int'(q_a), int'(din));
    end
    // R6: mid-cycle asynchronous reset while gated hold is requested
    cs_pri_n = 1; cs_sec_n = 1; din = '1; cke_in = 1; odt_in = 1;
    @(posedge clk); #1;
    rst_n = 0; #0.5;
    chk("R6", "async q_a clear", int'(q_a), 0);
    chk("R6", "async ctrl clear", int'({cs_a, cke_a, odt_a}), 0);
    phase = "R6";
    cycles(3);
    phase = "R7"; rst_n = 1; cycles(4);
    phase = "R2"; cs_pri_n = 0;
    for (int i = 0; i < 20; i++) begin rand_inputs(); @(negedge clk); end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule